// File: doc/BRIEF.md
# Run-time Width-Selectable Timer/Counter

This block is an up-counter behind a small byte-wide register bus. Software chooses between counting a fixed-rate internal tick, which fires once every four system clocks, and counting edges on an external pin. It also chooses which pin edge counts, whether a power-of-two prescaler sits in the count path, and whether the counter wraps at 8 or at 16 bits. On every wrap the block sets a sticky flag and drives the interrupt line from it.

The external pin may be asynchronous. It is brought into the clock domain by two flops, and an edge detector turns each chosen edge into a one-cycle count pulse. In 16-bit mode the upper count byte is reached only through a staging buffer, so that software can move the whole count with byte accesses. A read of the low byte copies the live high byte into the buffer. A write of the low byte loads the buffer into the high byte in the same edge.

Top module: `cfg_timer`

## Requirements
- R1: After reset, every register reads zero and irq is low. Register map by bus_addr: 0 = control, 1 = count low byte, 2 = high buffer, 3 = status (bit 0 = overflow flag).
- R2: While control bit 7 (run) is 0, the count does not change except through a bus write.
- R3: With control bit 5 (source) at 0 and the prescaler bypassed, the count advances by exactly one for every four system clocks.
- R4: With control bit 5 at 1, the count advances on edges of ext_in only, and internal ticks have no effect. Control bit 4 selects the edge: 0 for rising, 1 for falling. The edge counts on the third clock edge after the pin changes.
- R5: With control bit 3 (bypass) at 0, the count advances once per 2^(sel+1) source events, where sel is control bits 2:0. So 0 gives 1:2, 2 gives 1:8 and 7 gives 1:256. With bit 3 at 1, every event counts.
- R6: With control bit 6 (wide) at 0, the low byte wraps from FFh to 00h and sets the flag, and the high count byte is left untouched.
- R7: With control bit 6 at 1, the count wraps from FFFFh to 0000h and sets the flag.
- R8: In 16-bit mode, a bus read of the low byte copies the live high count byte into the high buffer.
- R9: In 16-bit mode, a write of the low byte loads both the written byte and the high buffer into the counter in one edge. A write of the high buffer alone leaves the count unchanged.
- R10: The flag holds until status is written with bit 0 = 0. Writing bit 0 = 1 has no effect. If a clear and a wrap happen in the same cycle, the flag ends up set. irq equals the flag.
- R11: A write of the low byte restarts the prescaler, so the next increment needs a full prescale period.
- R12: A level held on ext_in yields exactly one count, however long it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 1 | External count pin, asynchronous |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Overflow interrupt (sticky flag) |

## Verification
Several rules are checked by properties on every cycle. A stopped counter holds its value. A wrap sets the flag on the next edge, and a lone clear drops it. A low-byte write in wide mode commits exactly the buffer and the data. A low-byte read latches the live high byte. The prescaler counter is zero after a count write. The edge detector and the internal tick never fire on two cycles in a row. Only the directed scenarios can show the rates and counts: four clocks per tick, the 1:2, 1:8 and 1:256 ratios, the choice of edge, a held level counting once, a clear losing to a wrap in the same cycle, and the restart of the prescaler seen as a delayed increment.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic             run;
    logic             wide;
    logic             ext_sel;
    logic             fall_edge;
    logic             pre_bypass;
    logic [SEL_W-1:0] pre_sel;
  } tmr_ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LOW  = 2'd1;
  localparam logic [1:0] A_HBUF = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
endpackage

// File: rtl/tmr_src_sync.sv
module tmr_src_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    if (fall_sel_i) edge_o = !s2_q && prev_q;
    else            edge_o = s2_q && !prev_q;
  end

  p_edge_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || (fall_sel_i != $past(fall_sel_i))));
endmodule

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    tick_o = (div_q == LAST);
    div_d  = tick_o ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pulse_i,
  input  logic             bypass_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  localparam int CW = 1 << SEL_W;

  logic [CW-1:0] pcnt_q, pcnt_d, mask;

  always_comb begin
    for (int i = 0; i < CW; i++) mask[i] = (i <= int'(sel_i));
  end

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr_i)                     pcnt_d = '0;
    else if (pulse_i && !bypass_i) pcnt_d = pcnt_q + 1'b1;
  end

  always_comb begin
    if (bypass_i) pulse_o = pulse_i;
    else          pulse_o = pulse_i && ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  p_pre_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pcnt_q == '0));
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer
  import tmr_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_in,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  tmr_ctrl_t         ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] hbuf_q, hbuf_d;
  logic              flag_q, flag_d;
  logic              wr_ctrl, wr_low, wr_hbuf, wr_stat, rd_low;
  logic              ext_edge, int_tick, src_pulse, inc, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_low  = bus_wr && (bus_addr == A_LOW);
  assign wr_hbuf = bus_wr && (bus_addr == A_HBUF);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign rd_low  = bus_rd && (bus_addr == A_LOW);

  tmr_src_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pin_i      (ext_in),
    .fall_sel_i (ctrl_q.fall_edge),
    .edge_o     (ext_edge)
  );

  tmr_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (int_tick)
  );

  assign src_pulse = ctrl_q.run && (ctrl_q.ext_sel ? ext_edge : int_tick);

  tmr_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr_i    (wr_low),
    .pulse_i  (src_pulse),
    .bypass_i (ctrl_q.pre_bypass),
    .sel_i    (ctrl_q.pre_sel),
    .pulse_o  (inc)
  );

  always_comb begin
    ovf = inc && !wr_low &&
          (ctrl_q.wide ? (&cnt_q) : (&cnt_q[BYTE_W-1:0]));
  end

  always_comb begin
    ctrl_d = wr_ctrl ? tmr_ctrl_t'(bus_wdata) : ctrl_q;

    cnt_d = cnt_q;
    if (wr_low) begin
      if (ctrl_q.wide) cnt_d = {hbuf_q, bus_wdata};
      else             cnt_d = {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
    end else if (inc) begin
      if (ctrl_q.wide) cnt_d = cnt_q + 1'b1;
      else             cnt_d = {cnt_q[CNT_W-1:BYTE_W], cnt_q[BYTE_W-1:0] + 1'b1};
    end

    hbuf_d = hbuf_q;
    if (wr_hbuf)                    hbuf_d = bus_wdata;
    else if (rd_low && ctrl_q.wide) hbuf_d = cnt_q[CNT_W-1:BYTE_W];

    flag_d = flag_q;
    if (ovf)                        flag_d = 1'b1;
    else if (wr_stat && !bus_wdata[0]) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      hbuf_q <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      hbuf_q <= hbuf_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_LOW:   bus_rdata = cnt_q[BYTE_W-1:0];
      A_HBUF:  bus_rdata = hbuf_q;
      default: bus_rdata = {{(BYTE_W-1){1'b0}}, flag_q};
    endcase
  end

  assign irq = flag_q;

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_q.run && !wr_low) |=> $stable(cnt_q));
  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ovf |=> flag_q);
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_stat && !bus_wdata[0] && !ovf) |=> !flag_q);
  p_commit_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_low && ctrl_q.wide) |=> (cnt_q == {$past(hbuf_q), $past(bus_wdata)}));
  p_latch_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_low && ctrl_q.wide && !wr_hbuf) |=> (hbuf_q == $past(cnt_q[CNT_W-1:BYTE_W])));
  p_narrow_high_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_q.wide && !wr_low) |=> $stable(cnt_q[CNT_W-1:BYTE_W]));
endmodule

// File: tb/cfg_timer_bench.sv
module cfg_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_in = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [7:0] C_RUN = 8'h80, C_WIDE = 8'h40, C_EXT = 8'h20,
                         C_FALL = 8'h10, C_BYP = 8'h08;

  always #2 clk = ~clk;

  cfg_timer u_cfg_timer (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check("R1 reset reg", {8'h00, v}, 16'h0000);
    end
    check("R1 reset irq", {15'h0, irq}, 16'h0000);
  endtask

  task automatic t_internal_rate();
    logic [7:0] v;
    wr(2'd0, C_RUN | C_BYP);
    wr(2'd1, 8'h10);
    wait_cyc(40);
    peek(2'd1, v);
    check("R3 internal tick rate", {8'h00, v}, 16'h001A);
  endtask

  task automatic t_stop();
    logic [7:0] a, b;
    wr(2'd0, C_BYP);
    peek(2'd1, a);
    wait_cyc(40);
    peek(2'd1, b);
    check("R2 stopped count holds", {8'h00, b}, {8'h00, a});
  endtask

  task automatic t_prescale();
    logic [7:0] v;
    wr(2'd0, C_RUN | 8'h00);
    wr(2'd1, 8'h00);
    wait_cyc(24);
    peek(2'd1, v);
    check("R5 ratio 1:2", {8'h00, v}, 16'h0003);
    wr(2'd0, C_RUN | 8'h02);
    wr(2'd1, 8'h00);
    wait_cyc(96);
    peek(2'd1, v);
    check("R5 ratio 1:8", {8'h00, v}, 16'h0003);
    wr(2'd0, C_RUN | 8'h07);
    wr(2'd1, 8'h00);
    wait_cyc(2048);
    peek(2'd1, v);
    check("R5 ratio 1:256", {8'h00, v}, 16'h0002);
  endtask

  task automatic t_pre_restart();
    logic [7:0] v;
    wr(2'd0, C_RUN | 8'h02);
    wr(2'd1, 8'h00);
    repeat (20) @(posedge clk);
    @(negedge clk);
    wr(2'd1, 8'h00);
    wait_cyc(28);
    peek(2'd1, v);
    check("R11 restart delays increment", {8'h00, v}, 16'h0000);
    wait_cyc(4);
    peek(2'd1, v);
    check("R11 full period then increment", {8'h00, v}, 16'h0001);
  endtask

  task automatic t_wide_wrap();
    logic [7:0] lo, hi;
    wr(2'd3, 8'h00);
    wr(2'd0, C_RUN | C_WIDE | C_BYP);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFE);
    wait_cyc(8);
    rd(2'd1, lo);
    peek(2'd2, hi);
    check("R7 16-bit wrap value", {hi, lo}, 16'h0000);
    check("R7 16-bit wrap flag", {15'h0, irq}, 16'h0001);
  endtask

  task automatic t_atomic();
    logic [7:0] lo, hi;
    wr(2'd0, C_WIDE);
    wr(2'd2, 8'h12);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h56);
    rd(2'd1, lo);
    peek(2'd2, hi);
    check("R9 commit of buffer and low", {hi, lo}, 16'h1234);
    check("R8 read low latches high", {8'h00, hi}, 16'h0012);
  endtask

  task automatic t_narrow_wrap();
    logic [7:0] v;
    wr(2'd3, 8'h00);
    wr(2'd0, C_WIDE);
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'h00);
    wr(2'd0, C_RUN | C_BYP);
    wr(2'd1, 8'hFE);
    wait_cyc(8);
    peek(2'd1, v);
    check("R6 8-bit wrap low", {8'h00, v}, 16'h0000);
    check("R6 8-bit wrap flag", {15'h0, irq}, 16'h0001);
    wr(2'd0, C_WIDE);
    rd(2'd1, v);
    peek(2'd2, v);
    check("R6 high byte untouched", {8'h00, v}, 16'h005A);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    wr(2'd3, 8'h01);
    peek(2'd3, v);
    check("R10 write 1 no effect", {8'h00, v}, 16'h0001);
    wr(2'd3, 8'h00);
    peek(2'd3, v);
    check("R10 write 0 clears", {8'h00, v}, 16'h0000);
    check("R10 irq follows flag", {15'h0, irq}, 16'h0000);
  endtask

  task automatic pulse_ext();
    ext_in = 1'b1;
    repeat (3) @(negedge clk);
    ext_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_external();
    logic [7:0] v;
    ext_in = 1'b0;
    wr(2'd0, C_BYP);
    wr(2'd1, 8'h00);
    wr(2'd0, C_RUN | C_EXT | C_BYP);
    wait_cyc(20);
    peek(2'd1, v);
    check("R4 internal ticks ignored", {8'h00, v}, 16'h0000);
    for (int i = 0; i < 5; i++) pulse_ext();
    wait_cyc(5);
    peek(2'd1, v);
    check("R4 rising edges counted", {8'h00, v}, 16'h0005);
    wr(2'd0, C_RUN | C_EXT | C_FALL | C_BYP);
    for (int i = 0; i < 3; i++) pulse_ext();
    wait_cyc(5);
    peek(2'd1, v);
    check("R4 falling edges counted", {8'h00, v}, 16'h0008);
    ext_in = 1'b1;
    wait_cyc(2);
    peek(2'd1, v);
    check("R4 rise ignored in falling mode", {8'h00, v}, 16'h0008);
    wr(2'd0, C_RUN | C_EXT | C_BYP);
    ext_in = 1'b0;
    wait_cyc(5);
    ext_in = 1'b1;
    wait_cyc(30);
    peek(2'd1, v);
    check("R12 held level counts once", {8'h00, v}, 16'h0009);
    ext_in = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_race();
    logic [7:0] v;
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h00);
    ext_in = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(2'd3, 8'h00);
    peek(2'd3, v);
    check("R10 wrap beats clear", {8'h00, v}, 16'h0001);
    peek(2'd1, v);
    check("R4 third-edge latency", {8'h00, v}, 16'h0000);
    ext_in = 1'b0;
    wait_cyc(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_internal_rate();
    t_stop();
    t_prescale();
    t_pre_restart();
    t_wide_wrap();
    t_atomic();
    t_narrow_wrap();
    t_flag();
    t_external();
    t_race();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule